// File: doc/BRIEF.md
# Feedback Divider Dynamic Ramp Controller

This controller moves a running PLL from one feedback multiplier N to another without dropping lock, by handing the change to the PLL's built-in ramp circuit. A start pulse carries the requested N. The controller compares it with the N field of the live coefficient word. If the two match, it reports success at once. If they differ, it runs a fixed sequence. It loads the two ramp step constants and switches the PLL into slowdown mode. After a one-microsecond gap it rewrites the coefficient word with only the N field replaced. After a second gap it enables ramping.

The controller then samples a synchronized ramp-complete flag once per microsecond, up to a bounded number of samples. It leaves through a single exit step that always clears the slowdown and ramp-enable bits. That exit step raises either a success pulse or a timeout pulse. The microsecond tick comes from a prescaler on the system clock. The analog ramp is modelled by the ramp-complete input.

Top module: `ndiv_slide_ctrl`

## Requirements
- R1: A start whose requested N equals bits 15:8 of `coeff_cur` produces a `done` pulse on the next clock edge. In that case `busy` stays low, there is no coefficient write, and the step fields and mode bits keep their values.
- R2: For a differing N, exactly one single-cycle `coeff_we` strobe is issued. `coeff_wdata` equals `coeff_cur` with bits 15:8 replaced by the requested N. M (bits 7:0), the PL index (bits 21:16) and all other bits are carried over unchanged.
- R3: One edge after the start is accepted, `step_a` becomes STEP_A (default 0x2B) and `step_b` becomes STEP_B (default 0x0B). Both are set before slowdown is raised.
- R4: `slowdown` rises two edges after the start is accepted. It stays high through the coefficient write and the whole ramp.
- R5: The coefficient write comes TICK_DIV cycles after `slowdown` rises. `ramp_en` rises TICK_DIV cycles after the write.
- R6: After `ramp_en` rises, the controller samples the ramp-complete flag every TICK_DIV cycles. The flag is taken from `ramp_done_raw` through a two-flop synchronizer. A sampled 1 ends the sequence with a `done` pulse on the following edge.
- R7: If POLL_MAX samples in a row read 0, the sequence ends with a `timeout` pulse on the edge after the last sample. `done` and `timeout` are never high together.
- R8: On the edge that raises `done` or `timeout` after a ramp, both `slowdown` and `ramp_en` return to 0. This holds for success and for timeout.
- R9: `busy` is high from the edge after an accepted start until the edge that raises the end pulse. A `start` seen while `busy` is ignored, and so is any change of `req_n` during that time.
- R10: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| req_n | input | N_W | Requested feedback multiplier |
| coeff_cur | input | WORD_W | Current coefficient register value |
| ramp_done_raw | input | 1 | Asynchronous ramp-complete flag from the PLL |
| coeff_we | output | 1 | Coefficient register write strobe |
| coeff_wdata | output | WORD_W | Coefficient word to write |
| step_a | output | STEP_W | Ramp step constant A |
| step_b | output | STEP_W | Ramp step constant B |
| slowdown | output | 1 | Slowdown-using-PLL mode bit |
| ramp_en | output | 1 | Dynamic ramp enable bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Single-cycle success pulse |
| timeout | output | 1 | Single-cycle ramp-timeout pulse |

## Verification
The bench builds the controller with TICK_DIV = 4 and POLL_MAX = 6. With these values each microsecond gap is four cycles, and a complete timeout run fits in about 35 cycles. That makes it cheap to reach three cases in one run: success on the first sample, success on a later sample, and exhaustion of every sample. The default values do not change the sequence, only the length of each wait. The reference model tracks the coefficient register as it is rewritten by successive ramps, so the same-N shortcut is also exercised against a value that the controller itself wrote.

// File: rtl/ndiv_slide_ctrl.sv
module ndiv_slide_ctrl #(
  parameter int unsigned TICK_DIV = 100,
  parameter int unsigned POLL_MAX = 500,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned N_LSB    = 8,
  parameter int unsigned N_W      = 8,
  parameter int unsigned STEP_W   = 8,
  parameter logic [STEP_W-1:0] STEP_A = 'h2B,
  parameter logic [STEP_W-1:0] STEP_B = 'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_W-1:0]    req_n,
  input  logic [WORD_W-1:0] coeff_cur,
  input  logic              ramp_done_raw,
  output logic              coeff_we,
  output logic [WORD_W-1:0] coeff_wdata,
  output logic [STEP_W-1:0] step_a,
  output logic [STEP_W-1:0] step_b,
  output logic              slowdown,
  output logic              ramp_en,
  output logic              busy,
  output logic              done,
  output logic              timeout
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SMP_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(TICK_DIV - 1);
  localparam logic [SMP_W-1:0] SMP_LAST  = SMP_W'(POLL_MAX - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_STEP, S_SLOW, S_GAPN, S_GAPR, S_POLL, S_EXIT
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  us_cnt;
  logic [SMP_W-1:0]  n_smp;
  logic [N_W-1:0]    n_q;
  logic [1:0]        sync_q;
  logic              ok_q;
  logic              tick;
  logic              waiting;
  logic              flag_s;
  logic [WORD_W-1:0] merged;

  assign busy    = (state != S_IDLE);
  assign tick    = (us_cnt == TICK_LAST);
  assign waiting = (state == S_GAPN) || (state == S_GAPR) || (state == S_POLL);
  assign flag_s  = sync_q[1];

  always_comb begin
    merged = coeff_cur;
    merged[N_LSB +: N_W] = n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ramp_done_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       us_cnt <= '0;
    else if (!waiting || tick) us_cnt <= '0;
    else              us_cnt <= us_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      n_q         <= '0;
      n_smp       <= '0;
      ok_q        <= 1'b0;
      coeff_we    <= 1'b0;
      coeff_wdata <= '0;
      step_a      <= '0;
      step_b      <= '0;
      slowdown    <= 1'b0;
      ramp_en     <= 1'b0;
      done        <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      coeff_we <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (req_n == coeff_cur[N_LSB +: N_W]) begin
              done <= 1'b1;
            end else begin
              n_q   <= req_n;
              state <= S_STEP;
            end
          end
        end
        S_STEP: begin
          step_a <= STEP_A;
          step_b <= STEP_B;
          state  <= S_SLOW;
        end
        S_SLOW: begin
          slowdown <= 1'b1;
          state    <= S_GAPN;
        end
        S_GAPN: begin
          if (tick) begin
            coeff_we    <= 1'b1;
            coeff_wdata <= merged;
            state       <= S_GAPR;
          end
        end
        S_GAPR: begin
          if (tick) begin
            ramp_en <= 1'b1;
            n_smp   <= '0;
            state   <= S_POLL;
          end
        end
        S_POLL: begin
          if (tick) begin
            if (flag_s) begin
              ok_q  <= 1'b1;
              state <= S_EXIT;
            end else if (n_smp == SMP_LAST) begin
              ok_q  <= 1'b0;
              state <= S_EXIT;
            end else begin
              n_smp <= n_smp + 1'b1;
            end
          end
        end
        S_EXIT: begin
          slowdown <= 1'b0;
          ramp_en  <= 1'b0;
          done     <= ok_q;
          timeout  <= ~ok_q;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ndiv_slide_ctrl_chk.sv
module ndiv_slide_ctrl_chk #(
  parameter int unsigned STEP_W = 8,
  parameter logic [STEP_W-1:0] STEP_A = 'h2B,
  parameter logic [STEP_W-1:0] STEP_B = 'h0B
) (
  input logic              clk,
  input logic              rst_n,
  input logic              coeff_we,
  input logic [STEP_W-1:0] step_a,
  input logic [STEP_W-1:0] step_b,
  input logic              slowdown,
  input logic              ramp_en,
  input logic              busy,
  input logic              done,
  input logic              timeout
);

  AST_STEPS_BEFORE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slowdown) |-> (step_a == STEP_A) && (step_b == STEP_B)); // R3

  AST_RAMP_UNDER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> slowdown); // R4

  AST_WRITE_BEFORE_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    coeff_we |-> slowdown && !ramp_en && busy); // R5

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    coeff_we |=> !coeff_we); // R2

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R7

  AST_TIMEOUT_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(ramp_en)); // R7

  AST_EXIT_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !slowdown && !ramp_en); // R8

  AST_IDLE_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy); // R9

endmodule

bind ndiv_slide_ctrl ndiv_slide_ctrl_chk #(
  .STEP_W(STEP_W), .STEP_A(STEP_A), .STEP_B(STEP_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .coeff_we(coeff_we), .step_a(step_a),
  .step_b(step_b), .slowdown(slowdown), .ramp_en(ramp_en), .busy(busy),
  .done(done), .timeout(timeout)
);

// File: tb/test_ndiv_slide_ctrl.sv
module test_ndiv_slide_ctrl;
  localparam int T = 4;
  localparam int P = 6;
  localparam int BASE = 2 + 2 * T;
  localparam logic [31:0] INIT = 32'hA512_3456;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] req_n = '0;
  logic ramp_done_raw = 1'b0;
  logic [31:0] coeff_reg;
  logic coeff_we, slowdown, ramp_en, busy, done, timeout;
  logic [31:0] coeff_wdata;
  logic [7:0] step_a, step_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ndiv_slide_ctrl #(.TICK_DIV(T), .POLL_MAX(P)) i_ndiv_slide_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .req_n(req_n),
    .coeff_cur(coeff_reg), .ramp_done_raw(ramp_done_raw),
    .coeff_we(coeff_we), .coeff_wdata(coeff_wdata), .step_a(step_a),
    .step_b(step_b), .slowdown(slowdown), .ramp_en(ramp_en), .busy(busy),
    .done(done), .timeout(timeout)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) coeff_reg <= INIT;
    else if (coeff_we) coeff_reg <= coeff_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int k = -1;
  bit pend = 0, ok = 0;
  bit e_busy, e_slow, e_ramp, e_done, e_to, e_we;
  logic [7:0] e_sa, e_sb, m_n;
  logic [31:0] e_wd;
  bit hist[$];

  always @(posedge clk) begin
    bit ds;
    if (!rst_n) begin
      k = -1; pend = 0; e_busy = 0; e_slow = 0; e_ramp = 0; e_done = 0;
      e_to = 0; e_we = 0; e_sa = 0; e_sb = 0; e_wd = 0;
      hist = {1'b0, 1'b0};
    end else begin
      ds = hist[$-1];
      hist.push_back(ramp_done_raw);
      if (hist.size() > 4) void'(hist.pop_front());
      e_done = 0; e_to = 0; e_we = 0;
      if (k < 0) begin
        if (start) begin
          if (req_n == coeff_reg[15:8]) e_done = 1;
          else begin k = 0; m_n = req_n; e_busy = 1; end
        end
      end else if (pend) begin
        e_slow = 0; e_ramp = 0; e_busy = 0;
        e_done = ok; e_to = !ok; pend = 0; k = -1;
      end else begin
        k++;
        if (k == 1) begin e_sa = 8'h2B; e_sb = 8'h0B; end
        if (k == 2) e_slow = 1;
        if (k == 2 + T) begin
          e_we = 1;
          e_wd = {coeff_reg[31:16], m_n, coeff_reg[7:0]};
        end
        if (k == BASE) e_ramp = 1;
        if (k > BASE && (k - BASE) % T == 0) begin
          if (ds) begin pend = 1; ok = 1; end
          else if ((k - BASE) / T == P) begin pend = 1; ok = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    chk("R9 busy", busy, e_busy);
    chk("R4 slowdown", slowdown, e_slow);
    chk("R5 ramp_en", ramp_en, e_ramp);
    chk("R6 done", done, e_done);
    chk("R7 timeout", timeout, e_to);
    chk("R2 coeff_we", coeff_we, e_we);
    chk("R3 step_a", step_a, e_sa);
    chk("R3 step_b", step_b, e_sb);
    if (e_we) chk("R2 coeff_wdata", coeff_wdata, e_wd);
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual hung expected finished");
    finish_run();
  end

  task automatic go(logic [7:0] n);
    @(negedge clk); start = 1'b1; req_n = n;
    @(negedge clk); start = 1'b0;
  endtask

  bit got_done, got_to;
  task automatic wait_end();
    while (!(done || timeout)) @(negedge clk);
    got_done = done; got_to = timeout;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {coeff_we, slowdown, ramp_en, busy, done, timeout,
        step_a, step_b}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // same N: immediate success, nothing touched
    go(8'h34);
    chk("R1 done immediately", done, 1'b1);
    chk("R1 busy low", busy, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 coeff unchanged", coeff_reg, INIT);
    chk("R1 steps untouched", {step_a, step_b}, 16'h0);

    // ramp with late completion, stray start ignored
    go(8'h50);
    repeat (3) @(negedge clk);
    start = 1'b1; req_n = 8'h77;
    @(negedge clk); start = 1'b0;
    repeat (14) @(negedge clk);
    ramp_done_raw = 1'b1;
    wait_end();
    chk("R6 success pulse", {got_done, got_to}, 2'b10);
    chk("R8 mode bits cleared", {slowdown, ramp_en}, 2'b00);
    ramp_done_raw = 1'b0;
    @(negedge clk);
    chk("R2 only N replaced", coeff_reg, 32'hA512_5056);
    chk("R9 stray start ignored", coeff_reg[15:8], 8'h50);
    repeat (4) @(negedge clk);

    // no completion: timeout
    go(8'h21);
    wait_end();
    chk("R7 timeout pulse", {got_done, got_to}, 2'b01);
    chk("R8 mode bits cleared on timeout", {slowdown, ramp_en}, 2'b00);
    @(negedge clk);
    chk("R2 N written despite timeout", coeff_reg, 32'hA512_2156);
    repeat (4) @(negedge clk);

    // completion already present: first sample wins
    ramp_done_raw = 1'b1;
    go(8'h60);
    wait_end();
    chk("R6 first-sample success", {got_done, got_to}, 2'b10);
    ramp_done_raw = 1'b0;
    repeat (4) @(negedge clk);

    // same N against a value the controller wrote
    go(8'h60);
    chk("R1 shortcut after rewrite", {done, busy}, 2'b10);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule